// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block maps a 32-bit logical address to a physical address. It walks up to two levels of translation descriptors held in memory. One translation control word sets the layout of the walk: an enable bit, a bit that allows a separate supervisor root, a count of top address bits to skip, and the index width used at each level. Two root pointers are supplied as inputs, one for supervisor mode and one for normal mode. Each root pointer is a limit word, whose low two bits give the first-level descriptor format, and a table address.

A caller pulses `start_i` while the walker is idle. The walker latches the request and fetches descriptor words one at a time through a request/valid read port. It then pulses `done_o` for one cycle, with either a physical address or a fault flag. When translation is disabled the walk is skipped, and the logical address is returned one cycle after the start. A level-A descriptor can end the walk at once: this is a page descriptor whose base is added to the untranslated low bits. Otherwise it points to a level-B table, and the walk must end there. Invalid descriptors fault. So does any level-B pointer, because it would need a third level.

Top module: `pt_walker`

## Requirements
- R1: When control bit 31 is clear, `done_o` rises in the cycle after the accepted start, with `paddr_o` equal to the logical address, `fault_o` low and no memory read.
- R2: The supervisor root is used when control bit 25 and status bit 13 are both set. In every other case the normal root is used.
- R3: The skip count is control bits 19:16, and the level-A and level-B index widths are bits 15:12 and 11:8. The level-A index is the next A-width bits of the logical address below the skipped bits. The level-B index is the B-width bits below that.
- R4: Root limit bits 1:0 = 2 selects 4-byte descriptors at root base + index*4, and 3 selects 8-byte descriptors at root base + index*8. In both cases the root address has bits 1:0 cleared. A value of 0 or 1 faults without any read.
- R5: An 8-byte descriptor is read as two words, the type word first and then the address word at +4. The descriptor type is bits 1:0 of the first word. A 4-byte descriptor carries both in one word.
- R6: A level-A descriptor of type 2 or 3 selects a level-B table. The table base is the descriptor address with bits 3:0 cleared. The level-B descriptors use the 4-byte format for type 2 and the 8-byte format for type 3.
- R7: A type-1 descriptor ends the walk. `paddr_o` is then the descriptor address with bits 7:0 cleared, plus the logical address bits below the skip+A bits (at level A) or below the skip+A+B bits (at level B).
- R8: A type-0 descriptor at either level, or a type-2 or type-3 descriptor at level B, ends the walk with `fault_o` high and `paddr_o` zero.
- R9: `mem_req_o` stays high with a stable, word-aligned `mem_addr_o` until `mem_valid_i`. There is only one read at a time, and no request is made while idle.
- R10: After reset `done_o` and `mem_req_o` are low. `done_o` is a one-cycle pulse, and `paddr_o` and `fault_o` hold their values until the next walk ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a translation (taken only while idle) |
| laddr_i | input | 32 | Logical address |
| sr_i | input | 16 | Status word; bit 13 marks supervisor mode |
| tc_i | input | 32 | Translation control word |
| srp_lim_i | input | 32 | Supervisor root limit word |
| srp_ptr_i | input | 32 | Supervisor root table address |
| crp_lim_i | input | 32 | Normal root limit word |
| crp_ptr_i | input | 32 | Normal root table address |
| mem_req_o | output | 1 | Descriptor read request |
| mem_addr_o | output | 32 | Descriptor read address |
| mem_valid_i | input | 1 | Read data valid, completes the request |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | One-cycle result strobe |
| fault_o | output | 1 | Translation fault |
| paddr_o | output | 32 | Physical address |

## Verification
The assertions assume that `mem_valid_i` is raised only while `mem_req_o` is high. They also assume that the request inputs are sampled only in the cycle in which `start_i` is accepted. The stimulus answers reads only when a request is pending, and it inserts a wait cycle between requests. After each start it scrambles `laddr_i` and `tc_i`, so that any use of live inputs in place of the latched request shows up as a wrong result. Starts are issued only after the previous `done_o`.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int TC_EN_BIT    = 31;
  localparam int TC_SUP_BIT   = 25;
  localparam int SR_SUP_BIT   = 13;
  localparam int TC_IS_LSB    = 16;
  localparam int TC_AW_LSB    = 12;
  localparam int TC_BW_LSB    = 8;
  localparam int FIELD_W      = 4;

  typedef enum logic [1:0] {
    DT_INVALID = 2'd0,
    DT_PAGE    = 2'd1,
    DT_SHORT   = 2'd2,
    DT_LONG    = 2'd3
  } desc_type_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_A_W0,
    ST_A_W1,
    ST_B_W0,
    ST_B_W1,
    ST_DONE
  } walk_state_e;
endpackage

// File: rtl/ptw_root_sel.sv
module ptw_root_sel #(
  parameter int AW = 32
) (
  input  logic          sup_en_i,
  input  logic          sup_mode_i,
  input  logic [AW-1:0] srp_lim_i,
  input  logic [AW-1:0] srp_ptr_i,
  input  logic [AW-1:0] crp_lim_i,
  input  logic [AW-1:0] crp_ptr_i,
  output logic [1:0]    root_fmt_o,
  output logic [AW-1:0] root_base_o
);
  logic use_sup;
  assign use_sup = sup_en_i && sup_mode_i;

  always_comb begin
    if (use_sup) begin
      root_fmt_o  = srp_lim_i[1:0];
      root_base_o = {srp_ptr_i[AW-1:2], 2'b00};
    end else begin
      root_fmt_o  = crp_lim_i[1:0];
      root_base_o = {crp_ptr_i[AW-1:2], 2'b00};
    end
  end
endmodule

// File: rtl/ptw_idx_calc.sv
module ptw_idx_calc #(
  parameter int AW = 32,
  parameter int FW = 4
) (
  input  logic [AW-1:0] laddr_i,
  input  logic [FW-1:0] is_w_i,
  input  logic [FW-1:0] a_w_i,
  input  logic [FW-1:0] b_w_i,
  output logic [AW-1:0] idx_a_o,
  output logic [AW-1:0] idx_b_o,
  output logic [AW-1:0] off_a_o,
  output logic [AW-1:0] off_b_o
);
  localparam int SHW = $clog2(AW) + 2;
  localparam logic [SHW-1:0] AW_S = SHW'(AW);

  logic [SHW-1:0] sh_a, sh_b, rs_a, rs_b;
  logic [AW-1:0]  lsh_is, lsh_a, lsh_b;

  always_comb begin
    sh_a    = SHW'(is_w_i) + SHW'(a_w_i);
    sh_b    = sh_a + SHW'(b_w_i);
    rs_a    = AW_S - SHW'(a_w_i);
    rs_b    = AW_S - SHW'(b_w_i);
    lsh_is  = laddr_i << is_w_i;
    lsh_a   = laddr_i << sh_a;
    lsh_b   = laddr_i << sh_b;
    // shifts of AW or more give zero, covering zero-width fields
    idx_a_o = lsh_is >> rs_a;
    idx_b_o = lsh_a >> rs_b;
    off_a_o = lsh_a >> sh_a;
    off_b_o = lsh_b >> sh_b;
  end
endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
  import ptw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          en_i,
  input  logic [AW-1:0] laddr_i,
  input  logic [1:0]    root_fmt_i,
  input  logic [AW-1:0] root_base_i,
  input  logic [AW-1:0] idx_a_i,
  input  logic [AW-1:0] idx_b_i,
  input  logic [AW-1:0] off_a_i,
  input  logic [AW-1:0] off_b_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_valid_i,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic          fault_o,
  output logic [AW-1:0] paddr_o,
  output logic          busy_o
);
  walk_state_e   state_q;
  logic          long_q;
  logic [1:0]    type_q;
  logic [AW-1:0] addr_q, paddr_q;
  logic          fault_q;

  logic          lvl_b, first_word;
  desc_type_e    d_type;
  logic [AW-1:0] d_off;

  function automatic logic [AW-1:0] tbl_addr(input logic [AW-1:0] base,
                                             input logic [AW-1:0] idx,
                                             input logic lg);
    return base + (lg ? (idx << 3) : (idx << 2));
  endfunction

  always_comb begin
    lvl_b      = (state_q == ST_B_W0) || (state_q == ST_B_W1);
    first_word = (state_q == ST_A_W0) || (state_q == ST_B_W0);
    d_type     = desc_type_e'(first_word ? mem_rdata_i[1:0] : type_q);
    d_off      = lvl_b ? off_b_i : off_a_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      long_q  <= 1'b0;
      type_q  <= 2'b00;
      addr_q  <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          if (!en_i) begin
            paddr_q <= laddr_i;
            fault_q <= 1'b0;
            state_q <= ST_DONE;
          end else if (!root_fmt_i[1]) begin
            paddr_q <= '0;
            fault_q <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            long_q  <= root_fmt_i[0];
            addr_q  <= tbl_addr(root_base_i, idx_a_i, root_fmt_i[0]);
            state_q <= ST_A_W0;
          end
        end
        ST_A_W0, ST_A_W1, ST_B_W0, ST_B_W1: if (mem_valid_i) begin
          if (first_word && long_q) begin
            type_q  <= mem_rdata_i[1:0];
            addr_q  <= addr_q + AW'(4);
            state_q <= lvl_b ? ST_B_W1 : ST_A_W1;
          end else begin
            case (d_type)
              DT_PAGE: begin
                paddr_q <= {mem_rdata_i[AW-1:8], 8'h00} + d_off;
                fault_q <= 1'b0;
                state_q <= ST_DONE;
              end
              DT_SHORT, DT_LONG: begin
                if (lvl_b) begin
                  paddr_q <= '0;
                  fault_q <= 1'b1;
                  state_q <= ST_DONE;
                end else begin
                  long_q  <= d_type[0];
                  addr_q  <= tbl_addr({mem_rdata_i[AW-1:4], 4'h0}, idx_b_i, d_type[0]);
                  state_q <= ST_B_W0;
                end
              end
              default: begin
                paddr_q <= '0;
                fault_q <= 1'b1;
                state_q <= ST_DONE;
              end
            endcase
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (state_q == ST_A_W0) || (state_q == ST_A_W1) ||
                      (state_q == ST_B_W0) || (state_q == ST_B_W1);
  assign mem_addr_o = addr_q;
  assign done_o     = (state_q == ST_DONE);
  assign fault_o    = fault_q;
  assign paddr_o    = paddr_q;
  assign busy_o     = (state_q != ST_IDLE);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int AW  = 32,
  parameter int SRW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [AW-1:0]  laddr_i,
  input  logic [SRW-1:0] sr_i,
  input  logic [AW-1:0]  tc_i,
  input  logic [AW-1:0]  srp_lim_i,
  input  logic [AW-1:0]  srp_ptr_i,
  input  logic [AW-1:0]  crp_lim_i,
  input  logic [AW-1:0]  crp_ptr_i,
  output logic           mem_req_o,
  output logic [AW-1:0]  mem_addr_o,
  input  logic           mem_valid_i,
  input  logic [AW-1:0]  mem_rdata_i,
  output logic           done_o,
  output logic           fault_o,
  output logic [AW-1:0]  paddr_o
);
  logic          busy, accept;
  logic [AW-1:0] laddr_q, tc_q, laddr_m, tc_m;
  logic [1:0]    root_fmt;
  logic [AW-1:0] root_base;
  logic [AW-1:0] idx_a, idx_b, off_a, off_b;

  assign accept = start_i && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      laddr_q <= '0;
      tc_q    <= '0;
    end else if (accept) begin
      laddr_q <= laddr_i;
      tc_q    <= tc_i;
    end
  end

  // live request feeds the first step, latched copy the rest of the walk
  assign laddr_m = busy ? laddr_q : laddr_i;
  assign tc_m    = busy ? tc_q : tc_i;

  ptw_root_sel #(.AW(AW)) i_root_sel (
    .sup_en_i    (tc_i[TC_SUP_BIT]),
    .sup_mode_i  (sr_i[SR_SUP_BIT]),
    .srp_lim_i   (srp_lim_i),
    .srp_ptr_i   (srp_ptr_i),
    .crp_lim_i   (crp_lim_i),
    .crp_ptr_i   (crp_ptr_i),
    .root_fmt_o  (root_fmt),
    .root_base_o (root_base)
  );

  ptw_idx_calc #(.AW(AW), .FW(FIELD_W)) i_idx_calc (
    .laddr_i (laddr_m),
    .is_w_i  (tc_m[TC_IS_LSB +: FIELD_W]),
    .a_w_i   (tc_m[TC_AW_LSB +: FIELD_W]),
    .b_w_i   (tc_m[TC_BW_LSB +: FIELD_W]),
    .idx_a_o (idx_a),
    .idx_b_o (idx_b),
    .off_a_o (off_a),
    .off_b_o (off_b)
  );

  ptw_walk_fsm #(.AW(AW)) i_walk_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .en_i        (tc_i[TC_EN_BIT]),
    .laddr_i     (laddr_i),
    .root_fmt_i  (root_fmt),
    .root_base_i (root_base),
    .idx_a_i     (idx_a),
    .idx_b_i     (idx_b),
    .off_a_i     (off_a),
    .off_b_i     (off_b),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_valid_i (mem_valid_i),
    .mem_rdata_i (mem_rdata_i),
    .done_o      (done_o),
    .fault_o     (fault_o),
    .paddr_o     (paddr_o),
    .busy_o      (busy)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int AW  = 32,
  parameter int SRW = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           busy,
  input logic [AW-1:0]  laddr_i,
  input logic [SRW-1:0] sr_i,
  input logic [AW-1:0]  tc_i,
  input logic [AW-1:0]  srp_lim_i,
  input logic [AW-1:0]  crp_lim_i,
  input logic           mem_req_o,
  input logic [AW-1:0]  mem_addr_o,
  input logic           mem_valid_i,
  input logic           done_o,
  input logic           fault_o,
  input logic [AW-1:0]  paddr_o
);
  logic       acc;
  logic [1:0] fmt_live;
  assign acc      = start_i && !busy;
  assign fmt_live = (tc_i[25] && sr_i[13]) ? srp_lim_i[1:0] : crp_lim_i[1:0];

  AST_BYPASS_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !tc_i[31] |=> done_o && !fault_o && paddr_o == $past(laddr_i)); // R1
  AST_ROOT_FMT_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && tc_i[31] && !fmt_live[1] |=> done_o && fault_o && !mem_req_o); // R4
  AST_ADDR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00); // R4
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o)); // R9
  AST_NO_REQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mem_req_o); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(paddr_o) && $stable(fault_o)); // R10
  AST_FAULT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o |-> paddr_o == '0); // R8
endmodule

bind pt_walker pt_walker_chk #(.AW(AW), .SRW(SRW)) i_pt_walker_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy        (busy),
  .laddr_i     (laddr_i),
  .sr_i        (sr_i),
  .tc_i        (tc_i),
  .srp_lim_i   (srp_lim_i),
  .crp_lim_i   (crp_lim_i),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_valid_i (mem_valid_i),
  .done_o      (done_o),
  .fault_o     (fault_o),
  .paddr_o     (paddr_o)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] laddr_i = '0;
  logic [15:0] sr_i = '0;
  logic [31:0] tc_i = '0;
  logic [31:0] srp_lim = 32'h8000_0003, srp_ptr = 32'h0000_8002;
  logic [31:0] crp_lim = 32'h7FFF_0002, crp_ptr = 32'h0000_1001;
  logic        mem_req_o, mem_valid_i = 1'b0;
  logic [31:0] mem_addr_o, mem_rdata_i = '0;
  logic        done_o, fault_o;
  logic [31:0] paddr_o;

  int errs = 0, checks = 0, rd_cnt = 0;
  logic tog = 1'b0;
  logic [31:0] mem [logic [31:0]];

  always #4 clk = ~clk;

  pt_walker i_pt_walker (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .laddr_i(laddr_i), .sr_i(sr_i),
    .tc_i(tc_i), .srp_lim_i(srp_lim), .srp_ptr_i(srp_ptr), .crp_lim_i(crp_lim),
    .crp_ptr_i(crp_ptr), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_valid_i(mem_valid_i), .mem_rdata_i(mem_rdata_i), .done_o(done_o),
    .fault_o(fault_o), .paddr_o(paddr_o));

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(negedge clk) begin
    mem_valid_i = mem_req_o && tog;
    mem_rdata_i = rd(mem_addr_o);
    tog = ~tog;
  end

  always @(posedge clk) if (mem_req_o && mem_valid_i) rd_cnt++;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] desc_a(input int i);
    case (i % 4)
      0: return 32'h0000_0F0C;
      1: return (32'hA000_0000 + (i << 24)) | 32'hFD;
      2: return (32'h2000 + i * 32'h100) | 32'hE;
      default: return (32'h4000 + i * 32'h100) | 32'hF;
    endcase
  endfunction

  function automatic logic [31:0] page_b(input int i, input int j);
    return (32'h6000_0000 ^ (j << 24) ^ (i << 16)) | 32'hA5;
  endfunction

  // reference walk computed from the requirements
  task automatic ref_x(input logic [31:0] la, input logic [15:0] sr, input logic [31:0] tc,
                       output logic [31:0] pa, output bit f, output int nr);
    logic [31:0] lim, ptr, t1, ia, ib, addr, w0, w1, p, off;
    int is, ab, bb, sh;
    bit lg;
    logic [1:0] t;
    nr = 0; pa = 0; f = 0;
    if (!tc[31]) begin pa = la; return; end
    if (tc[25] && sr[13]) begin lim = srp_lim; ptr = srp_ptr; end
    else begin lim = crp_lim; ptr = crp_ptr; end
    if (lim[1:0] < 2) begin f = 1; return; end
    is = int'(tc[19:16]); ab = int'(tc[15:12]); bb = int'(tc[11:8]);
    t1 = la << is;   ia = t1 >> (32 - ab);
    t1 = la << (is + ab); ib = t1 >> (32 - bb);
    lg = lim[0];
    addr = {ptr[31:2], 2'b00} + (lg ? ia * 8 : ia * 4);
    w0 = rd(addr); nr++;
    if (lg) begin w1 = rd(addr + 4); nr++; p = w1; end else p = w0;
    t = w0[1:0];
    if (t == 0) begin f = 1; return; end
    if (t == 1) begin
      sh = is + ab; t1 = la << sh; off = t1 >> sh;
      pa = {p[31:8], 8'h00} + off; return;
    end
    lg = t[0];
    addr = {p[31:4], 4'h0} + (lg ? ib * 8 : ib * 4);
    w0 = rd(addr); nr++;
    if (lg) begin w1 = rd(addr + 4); nr++; p = w1; end else p = w0;
    if (w0[1:0] == 2'd1) begin
      sh = is + ab + bb; t1 = la << sh; off = t1 >> sh;
      pa = {p[31:8], 8'h00} + off;
    end else f = 1;
  endtask

  task automatic xlate(input logic [31:0] la, input logic [15:0] sr, input logic [31:0] tc,
                       input string tag);
    logic [31:0] epa, hold;
    bit ef;
    int enr, base, cyc;
    ref_x(la, sr, tc, epa, ef, enr);
    @(negedge clk);
    laddr_i = la; sr_i = sr; tc_i = tc; start_i = 1'b1;
    base = rd_cnt;
    @(negedge clk);
    start_i = 1'b0; laddr_i = ~la; tc_i = tc ^ 32'h000F_FF00;
    cyc = 0;
    while (!done_o && cyc < 200) begin @(posedge clk); #1; cyc++; end
    if (!done_o) begin
      chk(0, tag, "no done", 32'h0, 32'h1);
      return;
    end
    chk(fault_o == ef, tag, "fault", 32'(fault_o), 32'(ef));
    chk(paddr_o == epa, tag, "paddr", paddr_o, epa);
    chk(rd_cnt - base == enr, {tag, " R9"}, "reads", 32'(rd_cnt - base), 32'(enr));
    hold = paddr_o;
    @(posedge clk); #1;
    chk(!done_o && paddr_o == hold, "R10", "pulse/hold", paddr_o, hold);
  endtask

  function automatic logic [31:0] mk_tc(input int is);
    return 32'h8000_0000 | 32'h0200_0000 | (32'(is) << 16) | 32'h0000_4440;
  endfunction

  logic [31:0] seed = 32'h1234_5678;

  task automatic sweep(input int is, input logic [15:0] sr, input logic [31:0] tc,
                       input string tag);
    int pos;
    logic [31:0] la;
    pos = 28 - is;
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        la = (seed & ~(32'hFF << (pos - 4))) | (32'(a) << pos) | (32'(b) << (pos - 4));
        xlate(la, sr, tc, tag);
      end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[32'h1000 + 4 * i] = desc_a(i);
      mem[32'h8000 + 8 * i] = 32'h7FFF_FC00 | {30'h0, desc_a(i)[1:0]};
      mem[32'h8004 + 8 * i] = desc_a(i) ^ 32'h3;
      for (int j = 0; j < 16; j++) begin
        case (j % 3)
          0: mem[32'h2000 + i * 32'h100 + 4 * j] = page_b(i, j);
          1: mem[32'h2000 + i * 32'h100 + 4 * j] = 32'h1230_0000;
          default: mem[32'h2000 + i * 32'h100 + 4 * j] = 32'h0000_5006;
        endcase
        case (j % 3)
          0: mem[32'h4000 + i * 32'h100 + 8 * j] = 32'hFFFF_FC01;
          1: mem[32'h4000 + i * 32'h100 + 8 * j] = 32'h0000_0003;
          default: mem[32'h4000 + i * 32'h100 + 8 * j] = 32'h7FFF_FC00;
        endcase
        mem[32'h4004 + i * 32'h100 + 8 * j] = (page_b(i, j) & 32'hFFFF_FF00) | 32'h5A;
      end
    end
    repeat (3) @(posedge clk);
    #1;
    chk(!done_o, "R10", "reset done", 32'(done_o), 32'h0);
    chk(!mem_req_o, "R10", "reset req", 32'(mem_req_o), 32'h0);
    rst_n = 1'b1;
    // normal root, short format, skip 4
    sweep(4, 16'h0000, mk_tc(4), "R2 R3 R4 R6 R7 R8");
    // supervisor root, long format
    sweep(4, 16'h2000, mk_tc(4), "R2 R4 R5 R6 R7 R8");
    // supervisor mode but supervisor root disabled
    sweep(4, 16'h2000, mk_tc(4) & ~32'h0200_0000, "R2 R7 R8");
    // different skip count
    sweep(8, 16'h0000, mk_tc(8), "R3 R7 R8");
    // bypass
    for (int k = 0; k < 32; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      xlate(seed, 16'h2000, mk_tc(4) & ~32'h8000_0000, "R1");
    end
    // unsupported root formats
    for (int fm = 0; fm < 2; fm++) begin
      crp_lim = {30'h1FFF_C000, 2'(fm)};
      for (int k = 0; k < 4; k++) xlate(32'h0123_4567 * (k + 1), 16'h0, mk_tc(4), "R4");
    end
    crp_lim = 32'h7FFF_0002;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule